// File: doc/BRIEF.md
# 48-bit Filtered LFSR Keystream Generator

This block is the arithmetic heart of a small stream cipher. It holds a 48-bit shift-register state. After a start pulse it loads that state from a 48-bit key and a 32-bit serial number, then runs 32 mixing steps that fold a 32-bit nonce and the upper key bits into the state. Once mixing ends, each step shifts the register with linear feedback and produces one keystream bit. Every such bit comes from a two-level nonlinear filter over fixed state taps.

Keystream is drawn through a request/response stream. The requester presents a request (single bit, byte, or authenticator check) with `req_valid`, and the block takes it on a clock edge where `req_ready` is high. `req_ready` is high only while the block is initialised and idle, and it is low in any cycle where `start` is high. A bit or byte result appears on `out_data` with `out_valid`. The result stays there unchanged until a cycle in which `out_ready` is high. No new request is accepted and the state does not advance while a result waits. An authenticator check gives no stream output. It ends with a one-cycle `chk_done` pulse, and `chk_pass` holds the verdict until the next check ends. Framing, modulation and command decoding belong to surrounding logic.

Top module: `ks_keystream_gen`

## Requirements
- R1: Inputs are taken least-significant byte first (key byte 0 in `key_in[7:0]`, likewise for serial and nonce), and every byte is bit-reversed in place before use. With K, S and N the reversed key, serial and nonce, the state loads as {K[15:0], S[31:0]} on the edge that captures `start` while the block is not busy.
- R2: Mixing takes 32 clock edges. On step i (0..31), the state shifts right by one, and bit 47 takes the filter output of the shifted state XOR N[i] XOR K[i+16]. `busy` is high throughout. `done` is high for exactly one cycle, the cycle after the 32nd step, which is seen 33 falling edges after the one where `start` was driven.
- R3: A `start` pulse during mixing, or while a request is in progress, has no effect: mixing completes on the original schedule with the original inputs.
- R4: The keystream bit is a 5-input lookup into 0x7907287B. Its index is built from five 4-input lookups, and the lookup on taps (1,2,4,5) gives the index LSB, in order through the lookups on taps (7,11,13,14), (16,20,22,25), (27,28,30,32) and (33,42,43,45). The first and last of these use table 0x2C79 and the other three use 0x6671, and in each the first-listed tap is the LSB of the 4-bit index.
- R5: A running step takes the keystream bit from the state before the step. It then shifts right by one and writes into bit 47 the XOR of state bits 47,46,43,42,41,30,26,23,22,16,8,7,6,3,2,0.
- R6: `req_mode` 2'b00 requests one step, and the result is `out_data` = {7'b0, bit}.
- R7: `req_mode` 2'b01 requests eight steps, and the first generated bit lands in `out_data[7]`.
- R8: Successive requests continue the same keystream with no steps skipped or repeated.
- R9: `req_mode` 2'b1x runs 32 steps as four bytes. Byte k is compared with the complement of `req_auth[31-8k -: 8]` (first byte against bits 31:24). `chk_pass` is 1 only if all four match, and all 32 steps are consumed either way.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds and `req_ready` stays low, and the state does not advance.
- R11: After reset `busy`, `done`, `out_valid`, `chk_done`, `chk_pass` and `req_ready` are 0, and requests are refused until the first mixing completes.
- R12: A `start` while idle after earlier use reloads and remixes from the new inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load inputs and begin mixing (ignored while busy) |
| key_in | input | 48 | Key, byte 0 in the low bits |
| serial_in | input | 32 | Serial number, byte 0 in the low bits |
| nonce_in | input | 32 | Nonce, byte 0 in the low bits |
| busy | output | 1 | Mixing or a request in progress |
| done | output | 1 | One-cycle pulse when mixing finishes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_mode | input | 2 | 00 bit, 01 byte, 1x authenticator check |
| req_auth | input | 32 | Authenticator word for a check |
| out_valid | output | 1 | Keystream result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Keystream bit or byte |
| chk_done | output | 1 | One-cycle pulse when a check finishes |
| chk_pass | output | 1 | Verdict of the last check |

## Verification
On every cycle, the assertions check several structural rules. Each mixing or running step is a one-bit right shift of the previous state. `done` and `chk_done` never last two cycles. A waiting result stays frozen under back-pressure, `req_ready` never coincides with `busy`, and a start during mixing never restarts the step count. Only the bench scenarios can show that the bits are right. Those scenarios compare the keystream bytes and bits, the byte ordering, the pass/fail verdicts, the mixing latency and the continuity of the stream across requests with an independent model built from the tap lists and tables.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int ST_W       = 48;
  localparam int KEY_W      = 48;
  localparam int SER_W      = 32;
  localparam int NON_W      = 32;
  localparam int INIT_STEPS = 32;
  localparam int BYTE_W     = 8;
  localparam int AUTH_BYTES = 4;
  localparam int AUTH_W     = AUTH_BYTES * BYTE_W;
  localparam int N_LUT      = 5;
  localparam int LUT_IN     = 4;
  localparam int N_TAPS     = N_LUT * LUT_IN;
  localparam int CNT_W      = $clog2((INIT_STEPS > AUTH_W) ? INIT_STEPS : AUTH_W);
  localparam int BIDX_W     = $clog2(BYTE_W);

  localparam logic [15:0] LUT_A   = 16'h2C79;
  localparam logic [15:0] LUT_B   = 16'h6671;
  localparam logic [31:0] LUT_TOP = 32'h7907287B;
  localparam logic [N_LUT-1:0] USE_A = 5'b10001;

  localparam int unsigned TAPF [N_TAPS] = '{
    1, 2, 4, 5,  7, 11, 13, 14,  16, 20, 22, 25,  27, 28, 30, 32,  33, 42, 43, 45};

  localparam logic [ST_W-1:0] FB_MASK = 48'hCE00_44C1_01CD;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_READY, S_GEN, S_HOLD, S_AUTH
  } ks_state_e;
endpackage

// File: rtl/ks_byte_rev.sv
module ks_byte_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  for (genvar j = 0; j < NB; j++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign dout[8*j + 7 - b] = din[8*j + b];
    end
  end
endmodule

// File: rtl/ks_filter.sv
module ks_filter
  import ks_pkg::*;
(
  input  logic [N_TAPS-1:0] taps,
  output logic              ks
);
  logic [N_LUT-1:0] lvl1;

  for (genvar g = 0; g < N_LUT; g++) begin : g_lut
    logic [LUT_IN-1:0] idx;
    assign idx = taps[g*LUT_IN +: LUT_IN];
    if (USE_A[g]) begin : g_a
      assign lvl1[g] = LUT_A[idx];
    end else begin : g_b
      assign lvl1[g] = LUT_B[idx];
    end
  end

  assign ks = LUT_TOP[lvl1];
endmodule

// File: rtl/ks_core.sv
module ks_core
  import ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key_r,
  input  logic [SER_W-1:0] serial_r,
  input  logic [NON_W-1:0] nonce_r,
  input  logic             init_step,
  input  logic             run_step,
  output logic             ks_bit
);
  logic [ST_W-1:0]   st;
  logic [NON_W-1:0]  inj;
  logic [N_TAPS-1:0] run_taps, init_taps;
  logic              init_f;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign run_taps[t]  = st[TAPF[t]];
    assign init_taps[t] = st[TAPF[t] + 1];
  end

  ks_filter u_run_f  (.taps(run_taps),  .ks(ks_bit));
  ks_filter u_init_f (.taps(init_taps), .ks(init_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      inj <= '0;
    end else if (load) begin
      st  <= {key_r[15:0], serial_r};
      inj <= nonce_r ^ key_r[KEY_W-1:16];
    end else if (init_step) begin
      st  <= {init_f ^ inj[0], st[ST_W-1:1]};
      inj <= {1'b0, inj[NON_W-1:1]};
    end else if (run_step) begin
      st  <= {^(st & FB_MASK), st[ST_W-1:1]};
    end
  end

  // R2: each mixing step is a right shift of the prior state
  a_r2_init_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (init_step && !load) |=> st[ST_W-2:0] == $past(st[ST_W-1:1]));
  // R5: each running step is a right shift of the prior state
  a_r5_run_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (run_step && !load && !init_step) |=> st[ST_W-2:0] == $past(st[ST_W-1:1]));
  a_r5_step_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_step && init_step));
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [AUTH_W-1:0] req_auth,
  input  logic              out_ready,
  input  logic              ks_bit,
  output logic              load,
  output logic              init_step,
  output logic              run_step,
  output logic              busy,
  output logic              done,
  output logic              req_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              chk_done,
  output logic              chk_pass
);
  ks_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              byte_mode;
  logic [BYTE_W-1:0] acc;
  logic [AUTH_W-1:0] cmp;
  logic              miss;
  logic [BYTE_W-1:0] acc_next;
  logic              byte_end, byte_bad, accept;

  assign busy      = !(state == S_IDLE || state == S_READY);
  assign load      = start && !busy;
  assign req_ready = (state == S_READY) && !start;
  assign accept    = req_valid && req_ready;
  assign init_step = (state == S_INIT);
  assign run_step  = (state == S_GEN) || (state == S_AUTH);
  assign out_valid = (state == S_HOLD);
  assign out_data  = acc;

  assign acc_next  = {acc[BYTE_W-2:0], ks_bit};
  assign byte_end  = (cnt[BIDX_W-1:0] == BIDX_W'(BYTE_W-1));
  assign byte_bad  = (acc_next ^ {BYTE_W{1'b1}}) != cmp[AUTH_W-1 -: BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      byte_mode <= 1'b0;
      acc       <= '0;
      cmp       <= '0;
      miss      <= 1'b0;
      done      <= 1'b0;
      chk_done  <= 1'b0;
      chk_pass  <= 1'b0;
    end else begin
      done     <= 1'b0;
      chk_done <= 1'b0;
      case (state)
        S_IDLE, S_READY: begin
          if (load) begin
            state <= S_INIT;
            cnt   <= '0;
          end else if (accept) begin
            byte_mode <= req_mode[0];
            cmp       <= req_auth;
            miss      <= 1'b0;
            acc       <= '0;
            cnt       <= '0;
            state     <= req_mode[1] ? S_AUTH : S_GEN;
          end
        end
        S_INIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(INIT_STEPS-1)) begin
            state <= S_READY;
            done  <= 1'b1;
          end
        end
        S_GEN: begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
          if (!byte_mode || byte_end) state <= S_HOLD;
        end
        S_HOLD: begin
          if (out_ready) state <= S_READY;
        end
        S_AUTH: begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
          if (byte_end) begin
            if (byte_bad) miss <= 1'b1;
            cmp <= cmp << BYTE_W;
          end
          if (cnt == CNT_W'(AUTH_W-1)) begin
            state    <= S_READY;
            chk_done <= 1'b1;
            chk_pass <= !(miss || byte_bad);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_mix: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(state) == S_INIT);
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT && start) |=> (state == S_READY || cnt == $past(cnt) + 1'b1));
  a_r9_chk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy && !out_valid);
endmodule

// File: rtl/ks_keystream_gen.sv
module ks_keystream_gen
  import ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [SER_W-1:0]  serial_in,
  input  logic [NON_W-1:0]  nonce_in,
  output logic              busy,
  output logic              done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [AUTH_W-1:0] req_auth,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              chk_done,
  output logic              chk_pass
);
  logic [KEY_W-1:0] key_r;
  logic [SER_W-1:0] serial_r;
  logic [NON_W-1:0] nonce_r;
  logic load, init_step, run_step, ks_bit;

  ks_byte_rev #(.W(KEY_W)) u_rev_key (.din(key_in),    .dout(key_r));
  ks_byte_rev #(.W(SER_W)) u_rev_ser (.din(serial_in), .dout(serial_r));
  ks_byte_rev #(.W(NON_W)) u_rev_non (.din(nonce_in),  .dout(nonce_r));

  ks_core u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .key_r(key_r),
    .serial_r(serial_r), .nonce_r(nonce_r), .init_step(init_step),
    .run_step(run_step), .ks_bit(ks_bit)
  );

  ks_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_mode(req_mode), .req_auth(req_auth), .out_ready(out_ready),
    .ks_bit(ks_bit), .load(load), .init_step(init_step), .run_step(run_step),
    .busy(busy), .done(done), .req_ready(req_ready), .out_valid(out_valid),
    .out_data(out_data), .chk_done(chk_done), .chk_pass(chk_pass)
  );
endmodule

// File: tb/sim_ks_keystream_gen.sv
module sim_ks_keystream_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam logic [111:0] VECS [NVEC] = '{
    {48'h4F4E_4D49_4B52, 32'h49CA_B8F5, 32'h65F1_3A0C},
    {48'hFFFF_FFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {48'h0000_0000_0000, 32'h0000_0001, 32'h8000_0001},
    {48'h1234_5678_9ABC, 32'hDEAD_BEEF, 32'h0BAD_F00D}
  };
  localparam int TP [20] = '{1,2,4,5, 7,11,13,14, 16,20,22,25, 27,28,30,32, 33,42,43,45};
  localparam int FBT [16] = '{0,2,3,6,7,8,16,22,23,26,30,41,42,43,46,47};
  localparam logic [15:0] TA = 16'h2C79;
  localparam logic [15:0] TB = 16'h6671;
  localparam logic [31:0] TC = 32'h7907287B;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, start, req_valid, out_ready;
  logic [47:0] key_in;
  logic [31:0] serial_in, nonce_in, req_auth;
  logic [1:0]  req_mode;
  logic busy, done, req_ready, out_valid, chk_done, chk_pass;
  logic [7:0] out_data;

  ks_keystream_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
    .serial_in(serial_in), .nonce_in(nonce_in), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_auth(req_auth), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .chk_done(chk_done), .chk_pass(chk_pass)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- independent model ----
  logic [47:0] mx;

  function automatic logic [63:0] m_rev(input logic [63:0] v);
    logic [63:0] r;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 8; b++)
        r[8*j+7-b] = v[8*j+b];
    return r;
  endfunction

  function automatic logic m_f(input logic [47:0] x);
    logic [4:0] i5;
    logic [3:0] idx;
    for (int g = 0; g < 5; g++) begin
      for (int t = 0; t < 4; t++) idx[t] = x[TP[4*g+t]];
      i5[g] = (g == 0 || g == 4) ? TA[idx] : TB[idx];
    end
    return TC[i5];
  endfunction

  task automatic m_init(input logic [47:0] k, input logic [31:0] s, input logic [31:0] n);
    logic [63:0] kk, ss, nn;
    kk = m_rev({16'h0, k});
    ss = m_rev({32'h0, s});
    nn = m_rev({32'h0, n});
    mx = {kk[15:0], ss[31:0]};
    for (int i = 0; i < 32; i++) begin
      mx = mx >> 1;
      mx[47] = m_f(mx) ^ nn[i] ^ kk[i+16];
    end
  endtask

  task automatic m_bit(output logic b);
    logic fb;
    b = m_f(mx);
    fb = 1'b0;
    for (int t = 0; t < 16; t++) fb ^= mx[FBT[t]];
    mx = {fb, mx[47:1]};
  endtask

  task automatic m_byte(output logic [7:0] v);
    logic b;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_bit(b);
      v = {v[6:0], b};
    end
  endtask

  // ---- drivers ----
  task automatic do_start(input logic [47:0] k, input logic [31:0] s, input logic [31:0] n, output int cyc);
    @(negedge clk);
    key_in = k; serial_in = s; nonce_in = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_req(input logic [1:0] md, input logic [31:0] a, output logic [7:0] d, output logic p);
    int w;
    @(negedge clk);
    req_valid = 1'b1; req_mode = md; req_auth = a;
    w = 0;
    while (!req_ready && w < 100) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    d = 8'h00; p = 1'b0;
    if (md[1]) begin
      while (!chk_done && w < 100) begin
        @(negedge clk);
        w++;
      end
      p = chk_pass;
    end else begin
      while (!out_valid && w < 100) begin
        @(negedge clk);
        w++;
      end
      d = out_data;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, e, d0;
    logic p, eb;
    logic [7:0] ab [4];
    int cyc;
    bit seen;

    rst_n = 1'b0; start = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
    key_in = '0; serial_in = '0; nonce_in = '0; req_mode = 2'b00; req_auth = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid && !chk_done && !chk_pass && !req_ready, "R11 reset outputs",
        {busy, done, out_valid, chk_done, chk_pass, req_ready}, 0);
    rst_n = 1'b1;

    // R11: requests refused before first mixing
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'b01;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_valid || req_ready) seen = 1;
    end
    req_valid = 1'b0;
    chk(!seen, "R11 request refused before mixing", seen, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      do_start(VECS[v][111:64], VECS[v][63:32], VECS[v][31:0], cyc);
      chk(cyc == 33, "R2 mixing latency", cyc, 33);
      @(negedge clk);
      chk(!done, "R2 done is one cycle", done, 0);
      m_init(VECS[v][111:64], VECS[v][63:32], VECS[v][31:0]);
      do_req(2'b01, 32'h0, d, p);
      m_byte(e);
      chk(d == e, (v == 0) ? "R1 R4 R5 R7 first byte" : "R12 R1 R4 R5 R7 byte after restart", d, e);
      do_req(2'b00, 32'h0, d, p);
      m_bit(eb);
      chk(d == {7'b0, eb}, "R6 single bit", d, {7'b0, eb});
      do_req(2'b01, 32'h0, d, p);
      m_byte(e);
      chk(d == e, "R8 stream continues", d, e);
    end

    // R9 authenticator pass
    for (int i = 0; i < 4; i++) m_byte(ab[i]);
    do_req(2'b10, ~{ab[0], ab[1], ab[2], ab[3]}, d, p);
    chk(p == 1'b1, "R9 authenticator pass", p, 1);
    do_req(2'b01, 32'h0, d, p);
    m_byte(e);
    chk(d == e, "R9 byte after pass", d, e);

    // R9 authenticator fail on last byte; steps still consumed
    for (int i = 0; i < 4; i++) m_byte(ab[i]);
    do_req(2'b11, ~{ab[0], ab[1], ab[2], ab[3]} ^ 32'h0000_0001, d, p);
    chk(p == 1'b0, "R9 authenticator fail last byte", p, 0);
    do_req(2'b01, 32'h0, d, p);
    m_byte(e);
    chk(d == e, "R9 32 steps consumed on fail", d, e);

    // R9 byte order: swapped first two bytes must fail
    for (int i = 0; i < 4; i++) m_byte(ab[i]);
    if (ab[0] != ab[1]) begin
      do_req(2'b10, ~{ab[1], ab[0], ab[2], ab[3]}, d, p);
      chk(p == 1'b0, "R9 byte order", p, 0);
    end else begin
      do_req(2'b10, ~{ab[0], ab[1], ab[2], ab[3]}, d, p);
      chk(p == 1'b1, "R9 byte order (equal bytes)", p, 1);
    end

    // R10 back-pressure
    out_ready = 1'b0;
    do_req(2'b01, 32'h0, d0, p);
    m_byte(e);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!out_valid || out_data != d0 || req_ready) seen = 1;
    end
    chk(!seen, "R10 output held under back-pressure", seen, 0);
    chk(d0 == e, "R10 held byte value", d0, e);
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R10 released after ready", out_valid, 0);
    do_req(2'b01, 32'h0, d, p);
    m_byte(e);
    chk(d == e, "R10 no steps while held", d, e);

    // R3 start ignored while busy
    @(negedge clk);
    key_in = VECS[0][111:64]; serial_in = VECS[0][63:32]; nonce_in = VECS[0][31:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    repeat (4) begin @(negedge clk); cyc++; end
    key_in = VECS[3][111:64]; serial_in = VECS[3][63:32]; nonce_in = VECS[3][31:0]; start = 1'b1;
    @(negedge clk);
    cyc++; start = 1'b0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 33, "R3 latency unchanged by start while busy", cyc, 33);
    m_init(VECS[0][111:64], VECS[0][63:32], VECS[0][31:0]);
    do_req(2'b01, 32'h0, d, p);
    m_byte(e);
    chk(d == e, "R3 original inputs kept", d, e);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule